// File: doc/BRIEF.md
# SPI Register Slave with Deferred Reply

This block is the device side of a 16-bit serial register protocol. An external host selects it with an active-low chip select and clocks in one command per frame. The command is either a read or a write. It carries a 7-bit register address and an 8-bit data byte. The block holds a few control registers and a file of twelve configuration bytes, arranged as three banks of four. It exposes all of this state on parallel outputs so that neighbouring logic can use it.

The reply to a command is never returned in the frame that carries the command. It is prepared when that frame closes and is shifted out during the next frame. The reply holds the address of the register just accessed and that register's contents after the access. The serial pins are oversampled by the block's own clock. The host clock must therefore run well below the system clock, with each SCK phase at least three system clock cycles long.

Top module: `spi_regslave`

## Requirements
- R1: A frame is 16 bits, shifted least significant bit first. The slave samples MOSI on each falling SCK edge (clock idles low, second-edge sampling). Bit 0 selects the access type (0 = read, 1 = write), bits 7:1 hold the address, and bits 15:8 hold the write data. The data bits of a read are ignored.
- R2: The reply to a command appears on MISO during the next frame, least significant bit first, valid at every falling SCK edge. Its bit 0 is 0, bits 7:1 hold the address just accessed, and bits 15:8 hold that register's contents after the access. The first frame after reset replies 0x0000.
- R3: The reply data is 0x00 when the address does not exist (anything other than 0x1A, 0x1C, 0x1E and 0x53 to 0x5E), or when the software reset register 0x1A is read. The software reset register is write-only.
- R4: A frame takes effect only if CS_n rises after exactly 16 falling SCK edges. A shorter or longer frame changes no register and leaves the pending reply in place for the next frame.
- R5: Writing 0x03 to 0x1A raises `sw_rst_o` for exactly one clock cycle and returns all registers to their defaults: output enable 0, lock 1, every configuration byte 0x00. Writing any other value to 0x1A has no effect.
- R6: Writing 0x02 to 0x1C sets `oe_o`, and writing 0x01 clears it. Any other written value leaves it unchanged. Reading 0x1C returns `oe_o` in bit 0.
- R7: Writing 0x01 to 0x1E clears the lock, and writing 0x02 sets it. Any other written value leaves it unchanged. The lock is set after reset. Reading 0x1E returns the lock in bit 0, which is also driven on `lock_o`.
- R8: Configuration byte k (0 to 11) sits at address 0x53+k. Bank b, entry r is at 0x53+4b+r. Byte k drives `cfg_o[8k+7:8k]`. Reads always return the byte. Writes update it only while unlocked.
- R9: While locked, a write to a configuration address leaves the byte unchanged and is treated as a wrong-mode access, so its reply data is 0x00. Control registers remain writable while locked.
- R10: MISO is held low while CS_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial command data into the slave |
| miso | output | 1 | Serial reply data out of the slave |
| oe_o | output | 1 | Global output-enable register |
| lock_o | output | 1 | Configuration lock register |
| sw_rst_o | output | 1 | One-cycle pulse on a software reset |
| cfg_o | output | BANKS*REGS*8 | All configuration bytes, byte k at bits 8k+7:8k |

## Verification
The serial pins pass through a two-stage synchronizer before edge detection, so every effect lands a few system cycles after the SCK or CS_n edge that causes it. Register outputs change about four cycles after CS_n rises. A reply bit settles about four cycles after the preceding falling SCK edge. The bench waits eight cycles after CS_n rises before it compares the parallel outputs. It holds each SCK phase for four cycles and samples MISO just before it drives each falling edge. The scoreboard checks every reply one frame late, matching the pipelined protocol. Discarded frames push no expected item, so the pending reply carries forward to the next frame.

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int         BANKS     = 3,
  parameter int         REGS      = 4,
  parameter logic [6:0] CFG_BASE  = 7'h53,
  parameter logic [6:0] SRST_ADDR = 7'h1A,
  parameter logic [6:0] OEN_ADDR  = 7'h1C,
  parameter logic [6:0] LOCK_ADDR = 7'h1E
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic                    mosi,
  output logic                    miso,
  output logic                    oe_o,
  output logic                    lock_o,
  output logic                    sw_rst_o,
  output logic [BANKS*REGS*8-1:0] cfg_o
);
  localparam int         NCFG    = BANKS * REGS;
  localparam int         CW      = (NCFG > 1) ? $clog2(NCFG) : 1;
  localparam logic [6:0] CFG_END = CFG_BASE + 7'(NCFG);
  localparam logic [4:0] FLEN    = 5'd16;
  localparam logic [4:0] FCAP    = 5'd17;

  logic [2:0]  sck_s, cs_s;
  logic [1:0]  mosi_s;
  logic [15:0] rx_sh, tx_sh;
  logic [4:0]  bitcnt;
  logic [6:0]  rep_addr;
  logic [7:0]  rep_data;
  logic [7:0]  cfg_q [NCFG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= 3'b000;
      cs_s   <= 3'b111;
      mosi_s <= 2'b00;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end

  wire sel      = ~cs_s[1];
  wire sck_fall = sck_s[2] & ~sck_s[1];
  wire cs_fall  = cs_s[2] & ~cs_s[1];
  wire cs_rise  = ~cs_s[2] & cs_s[1];
  wire commit   = cs_rise & (bitcnt == FLEN);

  wire       wr = rx_sh[0];
  wire [6:0] a  = rx_sh[7:1];
  wire [7:0] d  = rx_sh[15:8];

  wire [6:0]    off    = a - CFG_BASE;
  wire [CW-1:0] idx    = off[CW-1:0];
  wire          is_cfg = (a >= CFG_BASE) && (a < CFG_END);
  wire          hit_sr = (a == SRST_ADDR);
  wire          hit_oe = (a == OEN_ADDR);
  wire          hit_lk = (a == LOCK_ADDR);

  wire srst_go = commit & wr & hit_sr & (d == 8'h03);
  wire cfg_go  = commit & wr & is_cfg & ~lock_o;

  wire oe_nx = (wr && hit_oe && d == 8'h02) ? 1'b1 :
               (wr && hit_oe && d == 8'h01) ? 1'b0 : oe_o;
  wire lk_nx = (wr && hit_lk && d == 8'h01) ? 1'b0 :
               (wr && hit_lk && d == 8'h02) ? 1'b1 : lock_o;

  logic [7:0] rd_nx;
  always_comb begin
    rd_nx = 8'h00;
    if (hit_oe)      rd_nx = {7'b0, oe_nx};
    else if (hit_lk) rd_nx = {7'b0, lk_nx};
    else if (is_cfg) begin
      if (!wr)         rd_nx = cfg_q[idx];
      else if (!lock_o) rd_nx = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh  <= '0;
      tx_sh  <= '0;
      bitcnt <= '0;
    end else if (cs_fall) begin
      bitcnt <= '0;
      tx_sh  <= {rep_data, rep_addr, 1'b0};
    end else if (sel && sck_fall) begin
      rx_sh  <= {mosi_s[1], rx_sh[15:1]};
      tx_sh  <= {1'b0, tx_sh[15:1]};
      bitcnt <= (bitcnt == FCAP) ? FCAP : bitcnt + 5'd1;
    end

  assign miso = sel & tx_sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rep_addr <= '0;
      rep_data <= '0;
    end else if (commit) begin
      rep_addr <= a;
      rep_data <= rd_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oe_o     <= 1'b0;
      lock_o   <= 1'b1;
      sw_rst_o <= 1'b0;
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
    end else begin
      sw_rst_o <= srst_go;
      if (srst_go) begin
        oe_o   <= 1'b0;
        lock_o <= 1'b1;
        for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
      end else if (commit) begin
        oe_o   <= oe_nx;
        lock_o <= lk_nx;
        if (cfg_go) cfg_q[idx] <= d;
      end
    end

  for (genvar g = 0; g < NCFG; g++) begin : g_flat
    assign cfg_o[g*8 +: 8] = cfg_q[g];
  end
endmodule

module spi_regslave_chk #(parameter int W = 96) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         miso,
  input logic         oe_o,
  input logic         lock_o,
  input logic         sw_rst_o,
  input logic [W-1:0] cfg_o
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |=> !sw_rst_o); // R5
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |-> (!oe_o && lock_o && cfg_o == '0)); // R5
  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> ($stable(cfg_o) || sw_rst_o)); // R9
  AST_PULSE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |-> $past(cs_n)); // R4
  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 2) && $past(cs_n) && cs_n) |-> !miso); // R10
endmodule

bind spi_regslave spi_regslave_chk #(.W(BANKS*REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .oe_o(oe_o),
  .lock_o(lock_o), .sw_rst_o(sw_rst_o), .cfg_o(cfg_o));

// File: tb/tb_spi_regslave.sv
module tb_spi_regslave;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso, oe_o, lock_o, sw_rst_o;
  logic [95:0] cfg_o;
  int n_cmp = 0, n_bad = 0, pulses = 0;

  logic       m_oe = 0, m_lock = 1;
  logic [7:0] m_cfg [12];
  logic [15:0] exp_q [$];
  logic [15:0] got;
  event got_ev;

  always #2.5 clk = ~clk;

  spi_regslave dut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .oe_o(oe_o), .lock_o(lock_o), .sw_rst_o(sw_rst_o), .cfg_o(cfg_o));

  always @(posedge clk) if (sw_rst_o) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each captured reply with the oldest expected one (R2)
  initial forever begin
    @(got_ev);
    #1;
    if (exp_q.size() == 0) chk("R2 empty queue", 32'(got), 32'hFFFF_FFFF);
    else chk("R2 reply", 32'(got), 32'(exp_q.pop_front()));
  end

  function automatic logic [15:0] model(input logic [15:0] c);
    logic wr; logic [6:0] a; logic [7:0] d, r;
    wr = c[0]; a = c[7:1]; d = c[15:8]; r = 8'h00;
    if (a == 7'h1A) begin
      if (wr && d == 8'h03) begin
        m_oe = 0; m_lock = 1;
        for (int i = 0; i < 12; i++) m_cfg[i] = 8'h00;
      end
    end else if (a == 7'h1C) begin
      if (wr && d == 8'h02) m_oe = 1;
      if (wr && d == 8'h01) m_oe = 0;
      r = {7'b0, m_oe};
    end else if (a == 7'h1E) begin
      if (wr && d == 8'h01) m_lock = 0;
      if (wr && d == 8'h02) m_lock = 1;
      r = {7'b0, m_lock};
    end else if (a >= 7'h53 && a <= 7'h5E) begin
      if (!wr) r = m_cfg[a - 7'h53];
      else if (!m_lock) begin m_cfg[a - 7'h53] = d; r = d; end
    end
    return {r, a, 1'b0};
  endfunction

  task automatic shift(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? tx[i] : 1'b0;
      sck = 1;
      repeat (4) @(negedge clk);
      if (i < 16) rx[i] = miso;
      sck = 0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] c);
    logic [15:0] rx;
    shift(c, 16, rx);
    got = rx;
    ->got_ev;
    exp_q.push_back(model(c));
    @(negedge clk);
  endtask

  function automatic logic [15:0] W(input logic [6:0] a, input logic [7:0] d);
    return {d, a, 1'b1};
  endfunction
  function automatic logic [15:0] RD(input logic [6:0] a);
    return {8'hC3, a, 1'b0};
  endfunction

  task automatic ports(input string req);
    chk({req, " oe_o"}, 32'(oe_o), 32'(m_oe));
    chk({req, " lock_o"}, 32'(lock_o), 32'(m_lock));
    for (int i = 0; i < 12; i++) chk({req, " cfg_o"}, 32'(cfg_o[i*8 +: 8]), 32'(m_cfg[i]));
  endtask

  initial begin
    logic [15:0] rx;
    int p0;
    for (int i = 0; i < 12; i++) m_cfg[i] = 8'h00;
    exp_q.push_back(16'h0000);               // R2 first reply after reset is zero
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    ports("R5 R7 reset defaults");
    chk("R10 miso idle", 32'(miso), 0);
    frame(RD(7'h1C));                        // R6 read oe
    frame(RD(7'h1E));                        // R7 read lock
    frame(W(7'h55, 8'hA5)); ports("R9 locked cfg write");
    frame(W(7'h1E, 8'h01)); ports("R7 unlock");
    frame(W(7'h53, 8'h11));                  // R8 bank 0 entry 0
    frame(W(7'h5E, 8'hEE));                  // R8 bank 2 entry 3
    frame(W(7'h58, 8'h3C)); ports("R8 cfg writes");
    frame(RD(7'h5E));                        // R8 read back
    frame(RD(7'h40));                        // R3 unknown address
    frame(RD(7'h1A));                        // R3 write-only register
    frame(W(7'h7F, 8'h55));                  // R3 unknown write
    frame(W(7'h1C, 8'h02)); ports("R6 oe set");
    frame(W(7'h1C, 8'h07)); ports("R6 other value");
    frame(W(7'h1C, 8'h01)); ports("R6 oe clear");
    // R4 short and long frames discarded, pending reply retained
    shift(W(7'h1C, 8'h02), 9, rx);  ports("R4 short frame");
    shift(W(7'h1C, 8'h02), 20, rx); ports("R4 long frame");
    frame(W(7'h1E, 8'h07)); ports("R7 other value");
    frame(W(7'h1C, 8'h02));
    frame(W(7'h1E, 8'h02)); ports("R7 lock");
    frame(W(7'h54, 8'h99)); ports("R9 locked write ignored");
    frame(W(7'h1C, 8'h01)); ports("R9 control writable while locked");
    frame(W(7'h1E, 8'h01));
    frame(W(7'h1C, 8'h02));
    p0 = pulses;
    frame(W(7'h1A, 8'h05)); ports("R5 other value");
    chk("R5 no pulse", 32'(pulses - p0), 0);
    frame(W(7'h1A, 8'h03)); ports("R5 software reset");
    chk("R5 one pulse", 32'(pulses - p0), 1);
    frame(RD(7'h58));                        // R1 read after reset
    frame(RD(7'h1E));
    repeat (4) @(negedge clk);
    chk("R10 miso idle end", 32'(miso), 0);
    chk("R2 queue drained to one", 32'(exp_q.size()), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule